// File: doc/BRIEF.md
# x86 Effective Address Generator

This block turns the addressing bytes of an x86 instruction into a memory operand offset. It takes the ModRM byte, the SIB byte that may follow it, up to four displacement bytes, the eight general registers, a segment-override flag and the base of the segment in use. From these it computes the effective address offset, whether the default segment becomes SS, how many addressing bytes follow the opcode, whether the operand is a register rather than memory, and whether a 4-byte access at the resulting linear address stays inside one 4 KB page.

Both address sizes are supported. A mode input selects 32-bit addressing, which uses base, scaled index and 8/32-bit displacements. Otherwise 16-bit addressing is used, with fixed base/index pairs, 8/16-bit displacements and the result wrapped to 16 bits. The decode is purely combinational. A single output register captures the result when `in_valid` is high and raises `out_valid` one cycle later. Segment limit checks and the memory access are left to the neighbouring logic.

The displacement input is byte-ordered as it comes from the instruction stream: `disp[7:0]` is the first displacement byte after the ModRM byte, or after the SIB byte when there is one. The register vector holds register n in bits `[32n+31:32n]`, in the order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI (n = 0..7).

Top module: `ea_gen`

## Requirements
- R1: When ModRM bits 7:6 equal 3 the result is a register operand: `is_reg`=1, `nbytes`=1, `ea_off`=0, `use_ss`=0 and `same_page`=0.
- R2: In 32-bit mode with ModRM rm (bits 2:0) not 4, the offset is register[rm] plus the displacement. Mod 0 adds nothing, mod 1 adds `disp[7:0]` sign-extended, and mod 2 adds `disp[31:0]`. The exception is mod 0 with rm 5, where the offset is `disp[31:0]` alone and no register is used.
- R3: In 32-bit mode with rm 4 a SIB byte is present. The offset is base register (SIB bits 2:0) + (index register (SIB bits 5:3) shifted left by SIB bits 7:6) + the mod displacement. An index field of 4 contributes zero.
- R4: In 32-bit mode a SIB base field of 5 with mod 0 uses no base register and adds `disp[31:0]` in its place.
- R5: In 32-bit mode the default segment becomes SS (`use_ss`=1) for rm 5 with a nonzero mod, and for a SIB base of 4 or 5, except base 5 with mod 0. `seg_ovr`=1 forces `use_ss`=0.
- R6: In 16-bit mode rm selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX for rm 0..7. The displacement is added, the sum wraps to 16 bits, and `ea_off[31:16]` is zero.
- R7: In 16-bit mode mod 0 with rm 6 gives the offset `disp[15:0]` alone. Mod 1 adds sign-extended `disp[7:0]` and mod 2 adds `disp[15:0]`.
- R8: In 16-bit mode rm 2, 3 and 6 (rm 6 only with a nonzero mod) set `use_ss`=1 unless `seg_ovr`=1.
- R9: For a memory operand, `nbytes` = 1 + (1 if a SIB byte is present) + displacement length (0, 1, 2 or 4).
- R10: For a memory operand, `same_page`=1 exactly when the low 12 bits of (`seg_base` + `ea_off`), taken modulo 4096, are at most 0xFFC.
- R11: The outputs are registered. Inputs applied with `in_valid`=1 appear one cycle later with `out_valid`=1. With `in_valid`=0 the next cycle has `out_valid`=0 and the outputs hold. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Capture the current decode |
| mode32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte (used when present) |
| disp | input | 32 | Displacement bytes, first byte in bits 7:0 |
| gpr_flat | input | 256 | Eight 32-bit registers, register n at bits 32n+31:32n |
| seg_ovr | input | 1 | A segment-override prefix is active |
| seg_base | input | 32 | Base of the segment in use |
| out_valid | output | 1 | Registered outputs are fresh |
| ea_off | output | 32 | Effective address offset |
| use_ss | output | 1 | Default segment switched to SS |
| nbytes | output | 3 | Addressing bytes after the opcode |
| is_reg | output | 1 | Operand is a register |
| same_page | output | 1 | 4-byte access stays within one 4 KB page |

## Verification
On every cycle the assertions check the following. The register-operand result follows mod 3. An override always clears the SS selection. 16-bit results never carry upper bits. A SIB decode always counts at least two bytes, and the byte count only takes reachable values. The page flag agrees with the captured segment base and the output offset. The valid strobe and hold behaviour also follow `in_valid`. The arithmetic itself is shown only by the bench's sweeps. These cover every ModRM value in both modes, every SIB value under each 32-bit SIB form, and two register sets chosen to force 16-bit wrap and negative 8-bit displacements. Directed page-edge cases at offsets 0xFFC and 0xFFD complete the picture.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int XLEN   = 32;
    localparam int NGPR   = 8;
    localparam int HLEN   = 16;
    localparam int CNT_W  = 3;

    typedef struct packed {
        logic [XLEN-1:0]  off;
        logic             dflt_ss;
        logic [CNT_W-1:0] dlen;
        logic             has_sib;
    } ea_part_t;

    typedef enum logic [1:0] {
        MOD_NODISP = 2'd0,
        MOD_DISP8  = 2'd1,
        MOD_DISPW  = 2'd2,
        MOD_REG    = 2'd3
    } mod_e;

    function automatic logic [XLEN-1:0] sx8_to_w(input logic [7:0] b);
        return {{(XLEN-8){b[7]}}, b};
    endfunction
endpackage

// File: rtl/ea_calc32.sv
module ea_calc32
    import ea_pkg::*;
(
    input  mod_e                       md,
    input  logic [2:0]                 rm,
    input  logic [7:0]                 sib,
    input  logic [XLEN-1:0]            disp,
    input  logic [NGPR-1:0][XLEN-1:0]  gpr,
    output ea_part_t                   res
);
    localparam int NSCALE = 4;

    logic [2:0] s_base;
    logic [2:0] s_idx;
    logic [1:0] s_scale;
    assign s_base  = sib[2:0];
    assign s_idx   = sib[5:3];
    assign s_scale = sib[7:6];

    logic [NSCALE-1:0][XLEN-1:0] idx_scaled;
    for (genvar k = 0; k < NSCALE; k++) begin : g_scale
        assign idx_scaled[k] = gpr[s_idx] << k;
    end

    logic [XLEN-1:0]  base_v;
    logic [XLEN-1:0]  idx_v;
    logic [XLEN-1:0]  disp_v;
    logic [CNT_W-1:0] dlen_v;
    logic             ss_v;
    logic             sib_v;

    always_comb begin
        base_v = '0;
        idx_v  = '0;
        ss_v   = 1'b0;
        sib_v  = 1'b0;
        unique case (md)
            MOD_NODISP: begin disp_v = '0;             dlen_v = 3'd0; end
            MOD_DISP8:  begin disp_v = sx8_to_w(disp[7:0]); dlen_v = 3'd1; end
            MOD_DISPW:  begin disp_v = disp;           dlen_v = 3'd4; end
            default:    begin disp_v = '0;             dlen_v = 3'd0; end
        endcase
        if (rm == 3'd4) begin
            sib_v = 1'b1;
            idx_v = (s_idx == 3'd4) ? '0 : idx_scaled[s_scale];
            if (md == MOD_NODISP && s_base == 3'd5) begin
                disp_v = disp;
                dlen_v = 3'd4;
            end else begin
                base_v = gpr[s_base];
                ss_v   = (s_base == 3'd4) || (s_base == 3'd5);
            end
        end else if (md == MOD_NODISP && rm == 3'd5) begin
            disp_v = disp;
            dlen_v = 3'd4;
        end else begin
            base_v = gpr[rm];
            ss_v   = (rm == 3'd5) && (md != MOD_NODISP);
        end
        res.off     = base_v + idx_v + disp_v;
        res.dflt_ss = ss_v;
        res.dlen    = dlen_v;
        res.has_sib = sib_v;
    end
endmodule

// File: rtl/ea_calc16.sv
module ea_calc16
    import ea_pkg::*;
(
    input  mod_e                       md,
    input  logic [2:0]                 rm,
    input  logic [HLEN-1:0]            disp,
    input  logic [NGPR-1:0][HLEN-1:0]  gpr16,
    output ea_part_t                   res
);
    localparam logic [2:0] IX_BX = 3'd3;
    localparam logic [2:0] IX_BP = 3'd5;
    localparam logic [2:0] IX_SI = 3'd6;
    localparam logic [2:0] IX_DI = 3'd7;

    logic [HLEN-1:0]  pair_v;
    logic [HLEN-1:0]  disp_v;
    logic [HLEN-1:0]  sum_v;
    logic [CNT_W-1:0] dlen_v;
    logic             ss_v;

    always_comb begin
        unique case (rm)
            3'd0: pair_v = gpr16[IX_BX] + gpr16[IX_SI];
            3'd1: pair_v = gpr16[IX_BX] + gpr16[IX_DI];
            3'd2: pair_v = gpr16[IX_BP] + gpr16[IX_SI];
            3'd3: pair_v = gpr16[IX_BP] + gpr16[IX_DI];
            3'd4: pair_v = gpr16[IX_SI];
            3'd5: pair_v = gpr16[IX_DI];
            3'd6: pair_v = gpr16[IX_BP];
            default: pair_v = gpr16[IX_BX];
        endcase
        unique case (md)
            MOD_NODISP: begin disp_v = '0; dlen_v = 3'd0; end
            MOD_DISP8:  begin disp_v = {{(HLEN-8){disp[7]}}, disp[7:0]}; dlen_v = 3'd1; end
            MOD_DISPW:  begin disp_v = disp; dlen_v = 3'd2; end
            default:    begin disp_v = '0; dlen_v = 3'd0; end
        endcase
        ss_v = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6);
        if (md == MOD_NODISP && rm == 3'd6) begin
            sum_v  = disp;
            dlen_v = 3'd2;
            ss_v   = 1'b0;
        end else begin
            sum_v = pair_v + disp_v;
        end
        res.off     = {{(XLEN-HLEN){1'b0}}, sum_v};
        res.dflt_ss = ss_v;
        res.dlen    = dlen_v;
        res.has_sib = 1'b0;
    end
endmodule

// File: rtl/ea_page_chk.sv
module ea_page_chk #(
    parameter int PAGE_W    = 12,
    parameter int ACC_BYTES = 4
) (
    input  logic [PAGE_W-1:0] base_lo,
    input  logic [PAGE_W-1:0] off_lo,
    output logic              fits
);
    localparam logic [PAGE_W-1:0] LAST_OK = PAGE_W'((1 << PAGE_W) - ACC_BYTES);

    logic [PAGE_W-1:0] lin_lo;
    assign lin_lo = base_lo + off_lo;
    assign fits   = (lin_lo <= LAST_OK);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int PAGE_W    = 12,
    parameter int ACC_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 mode32,
    input  logic [7:0]           modrm,
    input  logic [7:0]           sib,
    input  logic [XLEN-1:0]      disp,
    input  logic [NGPR*XLEN-1:0] gpr_flat,
    input  logic                 seg_ovr,
    input  logic [XLEN-1:0]      seg_base,
    output logic                 out_valid,
    output logic [XLEN-1:0]      ea_off,
    output logic                 use_ss,
    output logic [CNT_W-1:0]     nbytes,
    output logic                 is_reg,
    output logic                 same_page
);
    mod_e       md;
    logic [2:0] rm;
    assign md = mod_e'(modrm[7:6]);
    assign rm = modrm[2:0];

    logic [NGPR-1:0][XLEN-1:0] gpr;
    logic [NGPR-1:0][HLEN-1:0] gpr16;
    assign gpr = gpr_flat;
    for (genvar g = 0; g < NGPR; g++) begin : g_low
        assign gpr16[g] = gpr[g][HLEN-1:0];
    end

    ea_part_t r32, r16, rsel;

    ea_calc32 u_c32 (
        .md   (md),
        .rm   (rm),
        .sib  (sib),
        .disp (disp),
        .gpr  (gpr),
        .res  (r32)
    );

    ea_calc16 u_c16 (
        .md    (md),
        .rm    (rm),
        .disp  (disp[HLEN-1:0]),
        .gpr16 (gpr16),
        .res   (r16)
    );

    assign rsel = mode32 ? r32 : r16;

    logic page_fit;
    ea_page_chk #(.PAGE_W(PAGE_W), .ACC_BYTES(ACC_BYTES)) u_pg (
        .base_lo (seg_base[PAGE_W-1:0]),
        .off_lo  (rsel.off[PAGE_W-1:0]),
        .fits    (page_fit)
    );

    logic             reg_c;
    logic [XLEN-1:0]  off_c;
    logic             ss_c;
    logic [CNT_W-1:0] nb_c;
    logic             sp_c;

    always_comb begin
        reg_c = (md == MOD_REG);
        if (reg_c) begin
            off_c = '0;
            ss_c  = 1'b0;
            nb_c  = 3'd1;
            sp_c  = 1'b0;
        end else begin
            off_c = rsel.off;
            ss_c  = rsel.dflt_ss & ~seg_ovr;
            nb_c  = 3'd1 + {2'b00, rsel.has_sib} + rsel.dlen;
            sp_c  = page_fit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_off    <= '0;
            use_ss    <= 1'b0;
            nbytes    <= '0;
            is_reg    <= 1'b0;
            same_page <= 1'b0;
        end else if (in_valid) begin
            ea_off    <= off_c;
            use_ss    <= ss_c;
            nbytes    <= nb_c;
            is_reg    <= reg_c;
            same_page <= sp_c;
        end
    end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_pkg::*;
#(
    parameter int PAGE_W    = 12,
    parameter int ACC_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 mode32,
    input logic [7:0]           modrm,
    input logic                 seg_ovr,
    input logic [XLEN-1:0]      seg_base,
    input logic                 out_valid,
    input logic [XLEN-1:0]      ea_off,
    input logic                 use_ss,
    input logic [CNT_W-1:0]     nbytes,
    input logic                 is_reg,
    input logic                 same_page
);
    localparam logic [PAGE_W-1:0] LAST_OK = PAGE_W'((1 << PAGE_W) - ACC_BYTES);

    logic [PAGE_W-1:0] base_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        base_q <= '0;
        else if (in_valid) base_q <= seg_base[PAGE_W-1:0];
    end

    logic [PAGE_W-1:0] lin_q;
    assign lin_q = base_q + ea_off[PAGE_W-1:0];

    // R1
    reg_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && modrm[7:6] == 2'd3 |=> is_reg && nbytes == 3'd1 && !use_ss && !same_page && ea_off == '0);

    // R5
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && seg_ovr |=> !use_ss);

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mode32 |=> ea_off[XLEN-1:HLEN] == '0);

    // R9
    sib_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode32 && modrm[2:0] == 3'd4 && modrm[7:6] != 2'd3 |=> nbytes >= 3'd2);

    // R9
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> nbytes != 3'd0 && nbytes != 3'd4 && nbytes != 3'd7);

    // R10
    page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !is_reg |-> same_page == (lin_q <= LAST_OK));

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(ea_off) && $stable(nbytes) && $stable(use_ss));
endmodule

bind ea_gen ea_gen_chk #(.PAGE_W(PAGE_W), .ACC_BYTES(ACC_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode32    (mode32),
    .modrm     (modrm),
    .seg_ovr   (seg_ovr),
    .seg_base  (seg_base),
    .out_valid (out_valid),
    .ea_off    (ea_off),
    .use_ss    (use_ss),
    .nbytes    (nbytes),
    .is_reg    (is_reg),
    .same_page (same_page)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         mode32 = 1'b0;
    logic [7:0]   modrm = '0;
    logic [7:0]   sib = '0;
    logic [31:0]  disp = '0;
    logic [255:0] gpr_flat;
    logic         seg_ovr = 1'b0;
    logic [31:0]  seg_base = '0;
    logic         out_valid, use_ss, is_reg, same_page;
    logic [31:0]  ea_off;
    logic [2:0]   nbytes;

    logic [31:0] r [8];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) gpr_flat[32*i +: 32] = r[i];
    end

    ea_gen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode32(mode32),
        .modrm(modrm), .sib(sib), .disp(disp), .gpr_flat(gpr_flat),
        .seg_ovr(seg_ovr), .seg_base(seg_base), .out_valid(out_valid),
        .ea_off(ea_off), .use_ss(use_ss), .nbytes(nbytes),
        .is_reg(is_reg), .same_page(same_page)
    );

    logic [31:0] x_off;
    bit          x_reg, x_ss, x_sp;
    int          x_nb;

    task automatic expect_of(input bit m32, input logic [7:0] mr, input logic [7:0] sb, input bit ovr);
        int md, rmv, b, ix, sc;
        logic [15:0] a;
        logic [11:0] lo;
        md = int'(mr[7:6]); rmv = int'(mr[2:0]);
        x_reg = 0; x_ss = 0; x_sp = 0; x_off = 0; x_nb = 1;
        if (md == 3) begin
            x_reg = 1;
            return;
        end
        if (m32) begin
            if (rmv == 4) begin
                x_nb += 1;
                b = int'(sb[2:0]); ix = int'(sb[5:3]); sc = int'(sb[7:6]);
                if (ix != 4) x_off = r[ix] * (32'd1 << sc);
                if (b == 5 && md == 0) begin
                    x_off += disp; x_nb += 4;
                end else begin
                    x_off += r[b];
                    x_ss = (b == 4 || b == 5);
                end
            end else if (md == 0 && rmv == 5) begin
                x_off = disp; x_nb += 4;
            end else begin
                x_off = r[rmv];
                x_ss = (rmv == 5 && md != 0);
            end
            if (md == 1) begin x_off += {{24{disp[7]}}, disp[7:0]}; x_nb += 1; end
            if (md == 2) begin x_off += disp; x_nb += 4; end
        end else begin
            if (md == 0 && rmv == 6) begin
                a = disp[15:0]; x_nb += 2;
            end else begin
                case (rmv)
                    0: a = r[3][15:0] + r[6][15:0];
                    1: a = r[3][15:0] + r[7][15:0];
                    2: a = r[5][15:0] + r[6][15:0];
                    3: a = r[5][15:0] + r[7][15:0];
                    4: a = r[6][15:0];
                    5: a = r[7][15:0];
                    6: a = r[5][15:0];
                    default: a = r[3][15:0];
                endcase
                x_ss = (rmv == 2 || rmv == 3 || rmv == 6);
                if (md == 1) begin a += {{8{disp[7]}}, disp[7:0]}; x_nb += 1; end
                if (md == 2) begin a += disp[15:0]; x_nb += 2; end
            end
            x_off = {16'h0, a};
        end
        if (ovr) x_ss = 0;
        lo = seg_base[11:0] + x_off[11:0];
        x_sp = (lo <= 12'hFFC);
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic run_vec(input bit m32, input logic [7:0] mr, input logic [7:0] sb, input bit ovr);
        string tag;
        @(negedge clk);
        mode32 = m32; modrm = mr; sib = sb; seg_ovr = ovr; in_valid = 1'b1;
        expect_of(m32, mr, sb, ovr);
        @(negedge clk);
        if (mr[7:6] == 2'd3) tag = "R1";
        else if (!m32) tag = (mr[7:6] == 2'd0 && mr[2:0] == 3'd6) ? "R7" : "R6";
        else if (mr[2:0] == 3'd4) tag = (sb[2:0] == 3'd5 && mr[7:6] == 2'd0) ? "R4" : "R3";
        else tag = "R2";
        check(out_valid && is_reg == x_reg && ea_off == x_off, tag, {31'h0, is_reg, ea_off}, {31'h0, x_reg, x_off});
        check(use_ss == x_ss, m32 ? "R5 use_ss" : "R8 use_ss", 64'(use_ss), 64'(x_ss));
        check(int'(nbytes) == x_nb, "R9 nbytes", 64'(nbytes), 64'(x_nb));
        check(same_page == x_sp, "R10 same_page", 64'(same_page), 64'(x_sp));
    endtask

    task automatic sweep(input bit ovr);
        for (int m = 0; m < 2; m++) begin
            for (int mr = 0; mr < 256; mr++) begin
                int nsib;
                nsib = (m == 1 && (mr & 7) == 4 && (mr >> 6) != 3) ? 256 : 1;
                for (int s = 0; s < nsib; s++)
                    run_vec(m[0], 8'(mr), (nsib == 1) ? 8'h65 : 8'(s), ovr);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        r[0] = 32'h12345678; r[1] = 32'h8000FFF0; r[2] = 32'h00010020; r[3] = 32'hFFFF8001;
        r[4] = 32'h0000FF00; r[5] = 32'h7FFFFFF0; r[6] = 32'h00009000; r[7] = 32'hA5A5F00F;
        disp = 32'h80F12384; seg_base = 32'h00000123;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!out_valid && ea_off == 0 && nbytes == 0 && !use_ss && !is_reg && !same_page,
              "R11 reset", {31'h0, out_valid, ea_off}, 64'h0);
        rst_n = 1'b1;

        sweep(1'b0);

        r[0] = 32'h00000004; r[1] = 32'hFFFFFFFF; r[2] = 32'h40000000; r[3] = 32'h0000FFFE;
        r[4] = 32'h00000010; r[5] = 32'h0000FFF8; r[6] = 32'h00008001; r[7] = 32'h00000003;
        disp = 32'h7FFF017F; seg_base = 32'h00000FF0;
        sweep(1'b1);
        sweep(1'b0);

        // R10 page edge cases: absolute 32-bit displacement, mod 0 rm 5
        seg_base = 32'h0; disp = 32'h00000FFC; run_vec(1'b1, 8'h05, 8'h00, 1'b0);
        disp = 32'h00000FFD; run_vec(1'b1, 8'h05, 8'h00, 1'b0);
        seg_base = 32'h00000004; disp = 32'h00001FF8; run_vec(1'b1, 8'h05, 8'h00, 1'b0);
        seg_base = 32'h00000005; run_vec(1'b1, 8'h05, 8'h00, 1'b0);
        seg_base = 32'h00000FFF; disp = 32'h00000001; run_vec(1'b1, 8'h05, 8'h00, 1'b0);

        // R11 hold with in_valid low
        held = ea_off;
        @(negedge clk);
        in_valid = 1'b0; disp = 32'h11111111; modrm = 8'h80;
        @(negedge clk);
        check(!out_valid && ea_off == held, "R11 hold", {31'h0, out_valid, ea_off}, {32'h0, held});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule